// File: doc/BRIEF.md
# Compare-Match Interval Timer

This block is a bank of interval timer channels behind a simple word-addressed register bus. Every channel owns a control/status register, an up-counter and a compare register. A single shared run register holds one bit per channel, so software starts or stops any channel without touching the others. Counting is paced by `slow_tick`, a one-cycle pulse in the `clk` domain that marks each edge of the slow counting clock. A per-channel prescaler divides those pulses down to count ticks.

On a count tick where the counter equals the compare value, the counter returns to zero and the match flag is set. The interrupt line of that channel follows the flag whenever its enable bit is set, so the interrupt period is (compare + 1) count ticks. A write to the counter does not land at once. It is held for two slow-clock pulses, and only then does it replace the count.

Bus addresses are word indices; the fabric maps the byte stride. Word 0 is the shared run register. Channel k occupies words 4(k+1) to 4(k+1)+2: control/status, counter, compare. With a 16-bit counter the match flag is control bit 7 and the interrupt enable is bit 6. With a wider counter (the default, 32 bits) the match flag is bit 15, the wrap flag is bit 14 and the interrupt enable is bit 5. In both layouts, bits [1:0] select the prescale.

Top module: `cmt_timer`

## Requirements
- R1: After a synchronous reset, every control register reads 0, every counter reads 0, every compare register reads all ones, the run register reads 0 and every interrupt is low.
- R2: Bit k of the run register (word 0) starts channel k when 1 and stops it when 0. Writing the register changes no other channel's state, and the register reads back as written.
- R3: A running channel counts one tick per 8, 32, 128 or 512 `slow_tick` pulses, for control bits [1:0] equal to 0, 1, 2 or 3. On a tick where counter equals compare, the counter becomes 0 and the match flag (bit 15) is set, so matches recur every (compare + 1) × divisor pulses.
- R4: Writing 0 to a status flag bit clears it and writing 1 leaves it unchanged. A flag is never set by a bus write.
- R5: When a match and a write that clears the match flag fall in the same cycle, the flag ends up set.
- R6: A channel's interrupt is high exactly while its match flag and its enable bit (bit 5) are both set. It stays high until the flag is cleared or the enable is removed, and writing 0 to the control register drops it.
- R7: A counter write takes effect on the second `slow_tick` pulse after the write cycle, and reads return the old count until then. A pulse in the write cycle itself does not count.
- R8: While a channel's run bit is clear, its prescaler and counter hold, and its counter and compare registers stay readable and writable.
- R9: A new compare value is used by the very next count tick.
- R10: On a tick where the counter is all ones and does not equal compare, the counter wraps to 0 and the wrap flag (bit 14) is set, while the match flag and the interrupt stay unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus and logic clock |
| rst_n | input | 1 | Synchronous active-low reset |
| slow_tick | input | 1 | One-cycle pulse per slow counting-clock edge |
| bus_wen | input | 1 | Write strobe for the addressed word |
| bus_addr | input | ADDR_W | Word index |
| bus_wdata | input | CNT_W | Write data |
| bus_rdata | output | CNT_W | Read data of the addressed word, combinational |
| irq | output | NCH | Per-channel interrupt |

## Verification
The sensitive overlap is a count tick that produces a match in the same cycle as a bus write that clears the match flag. The bench provokes it by pacing `slow_tick` by hand. It first brings the prescaler to a known phase with a match, then issues exactly seven pulses. It drives the eighth pulse together with the clearing control write. The outcome is judged by reading the control register and the interrupt line afterwards: both must show the flag still set. A separate case checks that the same write with no pulse clears the flag.

// File: rtl/cmt_pkg.sv
// Shared constants and helpers for the compare-match timer.
// Assumes control registers are 16 bits wide in every counter width.
package cmt_pkg;

    localparam int CTL_W    = 16;
    localparam int PRE_BASE = 3;   // log2 of the smallest prescale
    localparam int PRE_STEP = 2;   // log2 step between prescale choices
    localparam int PRE_W    = PRE_BASE + 3 * PRE_STEP;

    typedef enum logic [1:0] {
        REG_CTL = 2'd0,
        REG_CNT = 2'd1,
        REG_CMP = 2'd2,
        REG_NONE = 2'd3
    } reg_sel_e;

    // Low-bit mask whose all-ones state marks the last pulse of a prescale period.
    function automatic logic [PRE_W-1:0] pre_mask(input logic [1:0] cks);
        logic [PRE_W-1:0] m;
        m = '0;
        for (int i = 0; i < PRE_W; i++) begin
            m[i] = (i < PRE_BASE + PRE_STEP * int'(cks));
        end
        return m;
    endfunction

endpackage

// File: rtl/cmt_prescaler.sv
// Divides slow-clock pulses into count ticks for one channel.
// Assumes slow_tick is a single-cycle pulse; holds its state while run is low.
module cmt_prescaler import cmt_pkg::*; (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       run,
    input  logic       slow_tick,
    input  logic [1:0] cks,
    output logic       tick
);

    logic [PRE_W-1:0] pre_q;
    logic [PRE_W-1:0] mask;

    assign mask = pre_mask(cks);
    assign tick = run && slow_tick && ((pre_q & mask) == mask);

    // Advance the divider on each slow pulse while running.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pre_q <= '0;
        end else if (run && slow_tick) begin
            pre_q <= pre_q + 1'b1;
        end
    end

endmodule

// File: rtl/cmt_cnt_sync.sv
// Holds a counter write until SYNC_N slow-clock pulses have passed.
// Assumes a new write restarts the delay; a pulse in the write cycle is not counted.
module cmt_cnt_sync #(
    parameter int W      = 32,
    parameter int SYNC_N = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wr,
    input  logic [W-1:0] wdata,
    input  logic         slow_tick,
    output logic         load,
    output logic [W-1:0] load_val
);

    localparam int SG_W = (SYNC_N > 2) ? $clog2(SYNC_N) : 1;
    localparam logic [SG_W-1:0] LAST = SG_W'(SYNC_N - 1);

    logic            pend_q;
    logic [SG_W-1:0] stage_q;
    logic [W-1:0]    val_q;

    assign load     = pend_q && slow_tick && !wr && (stage_q == LAST);
    assign load_val = val_q;

    // Capture a write and count slow pulses until it may be applied.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_q  <= 1'b0;
            stage_q <= '0;
            val_q   <= '0;
        end else if (wr) begin
            pend_q  <= 1'b1;
            stage_q <= '0;
            val_q   <= wdata;
        end else if (pend_q && slow_tick) begin
            if (stage_q == LAST) begin
                pend_q <= 1'b0;
            end else begin
                stage_q <= stage_q + 1'b1;
            end
        end
    end

endmodule

// File: rtl/cmt_channel.sv
// One timer channel: control/status, counter and compare with match and wrap flags.
// Assumes CNT_W >= 16; widths above 16 use the wide control layout.
module cmt_channel import cmt_pkg::*; #(
    parameter int CNT_W  = 32,
    parameter int SYNC_N = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic             slow_tick,
    input  logic             ctl_wr,
    input  logic             cnt_wr,
    input  logic             cmp_wr,
    input  logic [CNT_W-1:0] wdata,
    output logic [CTL_W-1:0] ctl_rd,
    output logic [CNT_W-1:0] cnt_o,
    output logic [CNT_W-1:0] cmp_o,
    output logic             flag_o,
    output logic             load_o,
    output logic             irq_o
);

    localparam bit WIDE     = (CNT_W > 16);
    localparam int FLAG_BIT = WIDE ? 15 : 7;
    localparam int OVF_BIT  = 14;
    localparam int IE_BIT   = WIDE ? 5 : 6;
    localparam logic [CTL_W-1:0] STAT_MASK = WIDE ? 16'hC000 : 16'h0080;

    logic [CTL_W-1:0] ctl_q;
    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] cmp_q;
    logic             mflag_q;
    logic             oflag;
    logic             tick;
    logic             at_cmp;
    logic             match_hit;
    logic             load;
    logic [CNT_W-1:0] load_val;

    cmt_prescaler u_pre (
        .clk       (clk),
        .rst_n     (rst_n),
        .run       (run),
        .slow_tick (slow_tick),
        .cks       (ctl_q[1:0]),
        .tick      (tick)
    );

    cmt_cnt_sync #(.W(CNT_W), .SYNC_N(SYNC_N)) u_sync (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr        (cnt_wr),
        .wdata     (wdata),
        .slow_tick (slow_tick),
        .load      (load),
        .load_val  (load_val)
    );

    assign at_cmp    = (cnt_q == cmp_q);
    assign match_hit = tick && at_cmp;

    // Control bits other than the status flags.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctl_q <= '0;
        end else if (ctl_wr) begin
            ctl_q <= wdata[CTL_W-1:0] & ~STAT_MASK;
        end
    end

    // Match flag: set by a match, cleared by writing 0; the match wins a tie.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mflag_q <= 1'b0;
        end else if (match_hit) begin
            mflag_q <= 1'b1;
        end else if (ctl_wr) begin
            mflag_q <= mflag_q & wdata[FLAG_BIT];
        end
    end

    generate
        if (WIDE) begin : g_wrap_flag
            logic oflag_q;
            logic ovf_hit;
            assign ovf_hit = tick && !at_cmp && (&cnt_q);
            // Wrap flag: set when the counter rolls over without a match.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    oflag_q <= 1'b0;
                end else if (ovf_hit) begin
                    oflag_q <= 1'b1;
                end else if (ctl_wr) begin
                    oflag_q <= oflag_q & wdata[OVF_BIT];
                end
            end
            assign oflag = oflag_q;
        end else begin : g_no_wrap_flag
            assign oflag = 1'b0;
        end
    endgenerate

    // Counter: delayed load first, otherwise count and return to zero on match.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= load_val;
        end else if (tick) begin
            cnt_q <= at_cmp ? '0 : cnt_q + 1'b1;
        end
    end

    // Compare register, resets to the longest period.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cmp_q <= '1;
        end else if (cmp_wr) begin
            cmp_q <= wdata;
        end
    end

    assign ctl_rd = ctl_q | (CTL_W'(mflag_q) << FLAG_BIT) | (CTL_W'(oflag) << OVF_BIT);
    assign cnt_o  = cnt_q;
    assign cmp_o  = cmp_q;
    assign flag_o = mflag_q;
    assign load_o = load;
    assign irq_o  = mflag_q && ctl_q[IE_BIT];

endmodule

// File: rtl/cmt_timer.sv
// Multi-channel compare-match timer with a shared run register and word-indexed bus.
// Assumes word 0 is the run register and channel k sits at words 4(k+1)..4(k+1)+2.
module cmt_timer import cmt_pkg::*; #(
    parameter int NCH    = 2,
    parameter int CNT_W  = 32,
    parameter int SYNC_N = 2,
    parameter int ADDR_W = $clog2(4 * (NCH + 1))
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              slow_tick,
    input  logic              bus_wen,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [CNT_W-1:0]  bus_wdata,
    output logic [CNT_W-1:0]  bus_rdata,
    output logic [NCH-1:0]    irq
);

    localparam int BLK_W = ADDR_W - 2;

    logic [BLK_W-1:0] blk;
    reg_sel_e         sel;
    logic             run_wr;
    logic [NCH-1:0]   run_q;
    logic [NCH-1:0]   ctl_wr;
    logic [NCH-1:0]   cnt_wr;
    logic [NCH-1:0]   cmp_wr;
    logic [NCH-1:0]   flag_v;
    logic [NCH-1:0]   load_v;
    logic [NCH-1:0][CTL_W-1:0] ctl_v;
    logic [NCH-1:0][CNT_W-1:0] cnt_v;
    logic [NCH-1:0][CNT_W-1:0] cmp_v;

    assign blk    = bus_addr[ADDR_W-1:2];
    assign sel    = reg_sel_e'(bus_addr[1:0]);
    assign run_wr = bus_wen && (blk == '0) && (sel == REG_CTL);

    // Shared run register, one bit per channel.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run_q <= '0;
        end else if (run_wr) begin
            run_q <= bus_wdata[NCH-1:0];
        end
    end

    generate
        for (genvar k = 0; k < NCH; k++) begin : g_ch
            logic hit;
            assign hit       = bus_wen && (blk == BLK_W'(k + 1));
            assign ctl_wr[k] = hit && (sel == REG_CTL);
            assign cnt_wr[k] = hit && (sel == REG_CNT);
            assign cmp_wr[k] = hit && (sel == REG_CMP);

            cmt_channel #(.CNT_W(CNT_W), .SYNC_N(SYNC_N)) u_ch (
                .clk       (clk),
                .rst_n     (rst_n),
                .run       (run_q[k]),
                .slow_tick (slow_tick),
                .ctl_wr    (ctl_wr[k]),
                .cnt_wr    (cnt_wr[k]),
                .cmp_wr    (cmp_wr[k]),
                .wdata     (bus_wdata),
                .ctl_rd    (ctl_v[k]),
                .cnt_o     (cnt_v[k]),
                .cmp_o     (cmp_v[k]),
                .flag_o    (flag_v[k]),
                .load_o    (load_v[k]),
                .irq_o     (irq[k])
            );
        end
    endgenerate

    // Read mux over the run register and every channel's registers.
    always_comb begin
        bus_rdata = '0;
        if ((blk == '0) && (sel == REG_CTL)) begin
            bus_rdata = CNT_W'(run_q);
        end
        for (int k = 0; k < NCH; k++) begin
            if (blk == BLK_W'(k + 1)) begin
                case (sel)
                    REG_CTL: bus_rdata = CNT_W'(ctl_v[k]);
                    REG_CNT: bus_rdata = cnt_v[k];
                    REG_CMP: bus_rdata = cmp_v[k];
                    default: bus_rdata = '0;
                endcase
            end
        end
    end

endmodule

// File: rtl/cmt_timer_checker.sv
// Temporal properties of the timer, attached to every instance of the top.
// Assumes the top exposes its per-channel state vectors under the bound names.
module cmt_timer_checker #(
    parameter int NCH   = 2,
    parameter int CNT_W = 32
) (
    input logic                      clk,
    input logic                      rst_n,
    input logic [NCH-1:0]            run_q,
    input logic [NCH-1:0]            ctl_wr,
    input logic [NCH-1:0]            cnt_wr,
    input logic [NCH-1:0]            irq,
    input logic [NCH-1:0]            flag_v,
    input logic [NCH-1:0]            load_v,
    input logic [NCH-1:0][CNT_W-1:0] cnt_v,
    input logic [NCH-1:0][CNT_W-1:0] cmp_v
);

    generate
        for (genvar k = 0; k < NCH; k++) begin : g_chk
            assert_reset_values_R1: assert property (@(posedge clk)
                !rst_n |=> (cmp_v[k] == '1 && cnt_v[k] == '0 && !irq[k]));

            assert_count_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
                (!$past(load_v[k]) && cnt_v[k] != $past(cnt_v[k]))
                |-> (cnt_v[k] == $past(cnt_v[k]) + 1'b1 || cnt_v[k] == '0));

            assert_flag_sticky_R4: assert property (@(posedge clk) disable iff (!rst_n)
                (flag_v[k] && !ctl_wr[k]) |=> flag_v[k]);

            assert_irq_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
                (irq[k] && !ctl_wr[k]) |=> irq[k]);

            assert_write_deferred_R7: assert property (@(posedge clk) disable iff (!rst_n)
                (cnt_wr[k] && !run_q[k]) |=> $stable(cnt_v[k]));

            assert_stopped_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
                (!run_q[k] && !load_v[k]) |=> $stable(cnt_v[k]));
        end
    endgenerate

endmodule

bind cmt_timer cmt_timer_checker #(.NCH(NCH), .CNT_W(CNT_W)) chk_i (
    .clk    (clk),
    .rst_n  (rst_n),
    .run_q  (run_q),
    .ctl_wr (ctl_wr),
    .cnt_wr (cnt_wr),
    .irq    (irq),
    .flag_v (flag_v),
    .load_v (load_v),
    .cnt_v  (cnt_v),
    .cmp_v  (cmp_v)
);

// File: tb/cmt_timer_tb_top.sv
// Self-checking bench: a period table walked by one loop, then directed corner cases.
module cmt_timer_tb_top;

    localparam int NCH   = 2;
    localparam int CNT_W = 32;
    localparam int AW    = $clog2(4 * (NCH + 1));

    localparam logic [AW-1:0] A_RUN  = AW'(0);
    localparam logic [AW-1:0] A_CTL0 = AW'(4);
    localparam logic [AW-1:0] A_CNT0 = AW'(5);
    localparam logic [AW-1:0] A_CMP0 = AW'(6);
    localparam logic [AW-1:0] A_CTL1 = AW'(8);
    localparam logic [AW-1:0] A_CNT1 = AW'(9);

    localparam int NV = 5;
    localparam logic [31:0] VEC_CMP [NV] = '{32'd0, 32'd2, 32'd1, 32'd3, 32'd0};
    localparam logic [31:0] VEC_CKS [NV] = '{32'd0, 32'd0, 32'd1, 32'd0, 32'd2};
    localparam int          VEC_EXP [NV] = '{8, 24, 64, 32, 128};

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             slow_tick = 1'b0;
    logic             bus_wen = 1'b0;
    logic [AW-1:0]    bus_addr = '0;
    logic [CNT_W-1:0] bus_wdata = '0;
    logic [CNT_W-1:0] bus_rdata;
    logic [NCH-1:0]   irq;

    int n_chk = 0;
    int n_bad = 0;

    always #5 clk = ~clk;

    cmt_timer #(.NCH(NCH), .CNT_W(CNT_W)) dut_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .slow_tick (slow_tick),
        .bus_wen   (bus_wen),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .irq       (irq)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // One clock with the given inputs; called and returns at a falling edge.
    task automatic step(input logic st, input logic we, input logic [AW-1:0] a, input logic [31:0] d);
        slow_tick = st;
        bus_wen   = we;
        bus_addr  = a;
        bus_wdata = d;
        @(posedge clk);
        @(negedge clk);
        slow_tick = 1'b0;
        bus_wen   = 1'b0;
    endtask

    task automatic pulse();
        step(1'b1, 1'b0, A_RUN, 32'd0);
    endtask

    task automatic wr(input logic [AW-1:0] a, input logic [31:0] d);
        step(1'b0, 1'b1, a, d);
    endtask

    task automatic rd(input logic [AW-1:0] a, output logic [31:0] d);
        bus_wen  = 1'b0;
        bus_addr = a;
        #1;
        d = bus_rdata;
    endtask

    task automatic pulses_to_flag(input int lim, output int n);
        logic [31:0] v;
        n = 0;
        do begin
            pulse();
            n++;
            rd(A_CTL0, v);
        end while (!v[15] && n < lim);
    endtask

    task automatic pulses_to_change(input int lim, output logic [31:0] v);
        logic [31:0] old;
        int n;
        rd(A_CNT0, old);
        n = 0;
        do begin
            pulse();
            n++;
            rd(A_CNT0, v);
        end while (v == old && n < lim);
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        n_bad++;
        n_chk++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin : main
        logic [31:0] v;
        int n;

        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1: reset values
        rd(A_CTL0, v); check("R1 ctl", v, 32'h0);
        rd(A_CNT0, v); check("R1 cnt", v, 32'h0);
        rd(A_CMP0, v); check("R1 cmp", v, 32'hFFFF_FFFF);
        rd(A_RUN, v);  check("R1 run", v, 32'h0);
        check("R1 irq", 32'(irq), 32'h0);

        // R2: run channel 0 only; one tick after 8 pulses at prescale code 0
        wr(A_RUN, 32'h1);
        rd(A_RUN, v); check("R2 run readback", v, 32'h1);
        repeat (8) pulse();
        rd(A_CNT0, v); check("R2 ch0 counts", v, 32'd1);
        rd(A_CNT1, v); check("R2 ch1 idle", v, 32'd0);
        wr(A_RUN, 32'h2);
        repeat (8) pulse();
        rd(A_CNT1, v); check("R2 ch1 counts", v, 32'd1);
        rd(A_CNT0, v); check("R8 ch0 holds when stopped", v, 32'd1);
        wr(A_RUN, 32'h0);

        // R7: delayed counter write; pulse in the write cycle does not count
        step(1'b1, 1'b1, A_CNT0, 32'd100);
        rd(A_CNT0, v); check("R7 old value after write", v, 32'd1);
        pulse();
        rd(A_CNT0, v); check("R7 old value after one pulse", v, 32'd1);
        pulse();
        rd(A_CNT0, v); check("R7 new value after two pulses", v, 32'd100);

        // R8: compare writable while stopped
        wr(A_CMP0, 32'd50);
        rd(A_CMP0, v); check("R8 cmp write stopped", v, 32'd50);

        // R3/R6: period table
        for (int i = 0; i < NV; i++) begin
            wr(A_RUN, 32'h0);
            wr(A_CTL0, 32'h20 | VEC_CKS[i]);
            wr(A_CMP0, VEC_CMP[i]);
            wr(A_CNT0, 32'd0);
            pulse();
            pulse();
            wr(A_RUN, 32'h1);
            pulses_to_flag(4000, n);
            wr(A_CTL0, 32'h20 | VEC_CKS[i]);
            pulses_to_flag(4000, n);
            check("R3 match period", 32'(n), 32'(VEC_EXP[i]));
            rd(A_CNT0, v); check("R3 counter zero after match", v, 32'd0);
            check("R6 irq on match", 32'(irq), 32'h1);
        end

        // R4/R6: flag write semantics and interrupt gating (ch0 flag set, cks=2)
        wr(A_CTL0, 32'h8022);
        rd(A_CTL0, v); check("R4 write 1 keeps flag", v, 32'h8022);
        check("R6 irq held", 32'(irq[0]), 32'h1);
        wr(A_CTL0, 32'h8002);
        rd(A_CTL0, v); check("R6 flag kept with enable off", v, 32'h8002);
        check("R6 irq off without enable", 32'(irq[0]), 32'h0);
        wr(A_CTL0, 32'h8022);
        check("R6 irq back with enable", 32'(irq[0]), 32'h1);
        wr(A_CTL0, 32'h0);
        rd(A_CTL0, v); check("R4 write 0 clears", v, 32'h0);
        check("R6 control 0 drops irq", 32'(irq[0]), 32'h0);

        // R5: clear write coincident with a match (cmp=0, cks=0)
        wr(A_CTL0, 32'h20);
        pulses_to_flag(100, n);
        wr(A_CTL0, 32'h20);
        rd(A_CTL0, v); check("R4 clear without match", v, 32'h20);
        repeat (7) pulse();
        rd(A_CTL0, v); check("R3 no early match", v, 32'h20);
        step(1'b1, 1'b1, A_CTL0, 32'h20);
        rd(A_CTL0, v); check("R5 match wins over clear", v, 32'h8020);
        check("R5 irq after tie", 32'(irq[0]), 32'h1);
        wr(A_CTL0, 32'h20);

        // R9: compare change used at the next tick
        wr(A_RUN, 32'h0);
        wr(A_CMP0, 32'hFFFF_FFFF);
        wr(A_CNT0, 32'd0);
        pulse();
        pulse();
        wr(A_RUN, 32'h1);
        n = 0;
        do begin
            pulse();
            n++;
            rd(A_CNT0, v);
        end while (v != 32'd3 && n < 100);
        check("R9 reached 3", v, 32'd3);
        wr(A_CMP0, 32'd3);
        pulses_to_change(20, v);
        check("R9 wraps on new compare", v, 32'd0);
        rd(A_CTL0, v); check("R9 flag from new compare", v, 32'h8020);

        // R10: wrap from all ones without a match
        wr(A_RUN, 32'h0);
        wr(A_CTL0, 32'h20);
        wr(A_CMP0, 32'd5);
        wr(A_CNT0, 32'hFFFF_FFFF);
        pulse();
        pulse();
        rd(A_CNT0, v); check("R7 load all ones", v, 32'hFFFF_FFFF);
        wr(A_RUN, 32'h1);
        pulses_to_change(20, v);
        check("R10 counter wraps to 0", v, 32'd0);
        rd(A_CTL0, v); check("R10 wrap flag only", v, 32'h4020);
        check("R10 no irq on wrap", 32'(irq[0]), 32'h0);
        wr(A_CTL0, 32'h4020);
        rd(A_CTL0, v); check("R10 write 1 keeps wrap flag", v, 32'h4020);
        wr(A_CTL0, 32'h20);
        rd(A_CTL0, v); check("R10 write 0 clears wrap flag", v, 32'h20);
        rd(A_CTL1, v); check("R2 ch1 control untouched", v, 32'h0);

        wr(A_RUN, 32'h0);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule